// File: doc/BRIEF.md
# Power-Good Timeout Supervisor with Margin Freeze

This block turns per-channel status flags into a power-good (reset release) output. Power-good is raised only after every channel marked active has reported its output as good, and both the supply-undervoltage flags and the enable flag are healthy, without a break for a programmable number of clock ticks. Any break clears the tick count. A loss of supply or enable pulls power-good low on the next edge.

The block also registers a raw fault request onto an active-low fault output. An active-low margin input supports system-level testing with supplies deliberately moved out of range. While margin is asserted, both outputs are frozen at their present values and monitoring stops. When margin is released, the timeout count starts again from zero.

The timeout is held in a loadable register. Its reset value corresponds to 200 µs at a 50 MHz clock (10000 ticks).

Top module: `pg_timeout_supervisor`

## Requirements
- R1: After reset, `pgood_o` is 0, `fault_no` is 1, and the timeout register holds `TMO_RST` (10000 by default).
- R2: A channel whose `chan_act_i` bit is 0 is ignored. Its `out_good_i` bit has no effect on `pgood_o`.
- R3: With the timeout register at T, `pgood_o` goes to 1 on the (T+1)-th consecutive rising edge at which margin is inactive and all of the following hold: every active good flag, every `uv_ok_i` bit, and `en_ok_i`.
- R4: If an active channel's good flag is 0 at an edge with margin inactive, `pgood_o` is 0 after that edge and the consecutive count restarts from zero.
- R5: If any `uv_ok_i` bit or `en_ok_i` is 0 at an edge with margin inactive, `pgood_o` is 0 after that edge and the count restarts from zero.
- R6: At any edge where `margin_ni` is 0, `pgood_o` and `fault_no` keep their values and the count is cleared.
- R7: After `margin_ni` returns to 1 with `pgood_o` low, a full T+1 consecutive qualifying edges are needed before `pgood_o` rises.
- R8: At an edge with `margin_ni` high, `fault_no` takes the inverse of `fault_req_i`.
- R9: `tmo_load_i` high at an edge loads `tmo_val_i` into the timeout register. The new value governs the count from the following edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| out_good_i | input | N_CH | Per-channel output above its good threshold |
| chan_act_i | input | N_CH | Per-channel active (monitored) flag |
| uv_ok_i | input | N_CH | Per-channel input supply above its undervoltage threshold |
| en_ok_i | input | 1 | Enable above its rising threshold |
| margin_ni | input | 1 | Margin test mode, active low |
| fault_req_i | input | 1 | Raw fault request |
| tmo_load_i | input | 1 | Load strobe for the timeout register |
| tmo_val_i | input | TMO_W | Timeout tick count to load |
| pgood_o | output | 1 | Power-good / reset release |
| fault_no | output | 1 | Fault output, active low |

## Verification
The bench first runs an uninterrupted good stretch with the reset timeout value, which separates a correct reset value from any other count. It then loads a short timeout. One good flag is broken mid-count, which shows whether the count restarts or merely pauses. An inactive channel is held low to confirm that masking works, and undervoltage and enable are lost separately to show that each one drops power-good alone. Margin is entered both with power-good high and with it low, while supplies and the fault request are disturbed, which separates a true freeze from normal tracking. The count after margin release is timed to show that it restarts.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int unsigned N_CH_DEF  = 3;
  localparam int unsigned TMO_W_DEF = 16;
  localparam int unsigned TMO_RST_DEF = 10000; // 200 us at 50 MHz
endpackage

// File: rtl/pg_qual.sv
module pg_qual #(
  parameter int unsigned N_CH = 3
) (
  input  logic [N_CH-1:0] out_good_i,
  input  logic [N_CH-1:0] chan_act_i,
  input  logic [N_CH-1:0] uv_ok_i,
  input  logic            en_ok_i,
  output logic            qual_o
);
  logic [N_CH-1:0] ch_ok;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign ch_ok[g] = out_good_i[g] | ~chan_act_i[g];
  end

  assign qual_o = (&ch_ok) & (&uv_ok_i) & en_ok_i;
endmodule

// File: rtl/pg_timer.sv
module pg_timer #(
  parameter int unsigned TMO_W   = 16,
  parameter int unsigned TMO_RST = 10000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             qual_i,
  input  logic             tmo_load_i,
  input  logic [TMO_W-1:0] tmo_val_i,
  output logic             done_o
);
  localparam logic [TMO_W-1:0] TmoRst = TMO_W'(TMO_RST);

  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W-1:0] tmo_q;

  assign done_o = (cnt_q >= tmo_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tmo_q <= TmoRst;
    end else begin
      if (tmo_load_i) tmo_q <= tmo_val_i;
      if (!run_i || !qual_i) cnt_q <= '0;
      else if (!done_o)      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pg_hold.sv
module pg_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic qual_i,
  input  logic done_i,
  input  logic fault_req_i,
  output logic pgood_o,
  output logic fault_no
);
  logic pg_q, flt_q;

  // frozen while run_i is low (margin)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_q  <= 1'b0;
      flt_q <= 1'b0;
    end else if (run_i) begin
      flt_q <= fault_req_i;
      if (!qual_i)     pg_q <= 1'b0;
      else if (done_i) pg_q <= 1'b1;
    end
  end

  assign pgood_o  = pg_q;
  assign fault_no = ~flt_q;
endmodule

// File: rtl/pg_timeout_supervisor.sv
module pg_timeout_supervisor
  import pg_pkg::*;
#(
  parameter int unsigned N_CH    = N_CH_DEF,
  parameter int unsigned TMO_W   = TMO_W_DEF,
  parameter int unsigned TMO_RST = TMO_RST_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CH-1:0]  out_good_i,
  input  logic [N_CH-1:0]  chan_act_i,
  input  logic [N_CH-1:0]  uv_ok_i,
  input  logic             en_ok_i,
  input  logic             margin_ni,
  input  logic             fault_req_i,
  input  logic             tmo_load_i,
  input  logic [TMO_W-1:0] tmo_val_i,
  output logic             pgood_o,
  output logic             fault_no
);
  logic qual, done;

  pg_qual #(.N_CH(N_CH)) u_qual (
    .out_good_i (out_good_i),
    .chan_act_i (chan_act_i),
    .uv_ok_i    (uv_ok_i),
    .en_ok_i    (en_ok_i),
    .qual_o     (qual)
  );

  pg_timer #(.TMO_W(TMO_W), .TMO_RST(TMO_RST)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (margin_ni),
    .qual_i     (qual),
    .tmo_load_i (tmo_load_i),
    .tmo_val_i  (tmo_val_i),
    .done_o     (done)
  );

  pg_hold u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (margin_ni),
    .qual_i      (qual),
    .done_i      (done),
    .fault_req_i (fault_req_i),
    .pgood_o     (pgood_o),
    .fault_no    (fault_no)
  );
endmodule

// File: rtl/pg_timeout_supervisor_chk.sv
module pg_timeout_supervisor_chk #(
  parameter int unsigned N_CH = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_CH-1:0] out_good_i,
  input logic [N_CH-1:0] chan_act_i,
  input logic [N_CH-1:0] uv_ok_i,
  input logic            en_ok_i,
  input logic            margin_ni,
  input logic            fault_req_i,
  input logic            pgood_o,
  input logic            fault_no
);
  logic act_bad;
  assign act_bad = |(chan_act_i & ~out_good_i);

  // R4
  good_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (margin_ni && act_bad) |=> !pgood_o);

  // R5
  supply_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (margin_ni && (!en_ok_i || !(&uv_ok_i))) |=> !pgood_o);

  // R6
  margin_pg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !margin_ni |=> $stable(pgood_o));

  // R6
  margin_flt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !margin_ni |=> $stable(fault_no));

  // R8
  fault_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    margin_ni |=> (fault_no == !$past(fault_req_i)));

  // R7
  pg_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pgood_o) |-> $past(margin_ni));
endmodule

bind pg_timeout_supervisor pg_timeout_supervisor_chk #(.N_CH(N_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .out_good_i  (out_good_i),
  .chan_act_i  (chan_act_i),
  .uv_ok_i     (uv_ok_i),
  .en_ok_i     (en_ok_i),
  .margin_ni   (margin_ni),
  .fault_req_i (fault_req_i),
  .pgood_o     (pgood_o),
  .fault_no    (fault_no)
);

// File: tb/pg_timeout_supervisor_test.sv
module pg_timeout_supervisor_test;
  localparam int N = 3;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] good = '0, act = '1, uv = '1;
  logic en = 1'b1, mrg_n = 1'b1, freq = 1'b0, ld = 1'b0;
  logic [W-1:0] ldv = '0;
  logic pgood, fault_n;

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  // reference model state
  int m_cnt = 0, m_tmo = 10000;
  bit m_pg = 0, m_flt = 0;

  always #10 clk = ~clk;

  pg_timeout_supervisor uut (
    .clk_i(clk), .rst_ni(rst_n), .out_good_i(good), .chan_act_i(act),
    .uv_ok_i(uv), .en_ok_i(en), .margin_ni(mrg_n), .fault_req_i(freq),
    .tmo_load_i(ld), .tmo_val_i(ldv), .pgood_o(pgood), .fault_no(fault_n)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_tmo = 10000; m_pg = 0; m_flt = 0;
    end else begin
      bit q;
      q = en;
      for (int i = 0; i < N; i++) begin
        if (!uv[i]) q = 0;
        if (act[i] && !good[i]) q = 0;
      end
      if (mrg_n) begin
        m_flt = freq;
        if (!q) begin m_pg = 0; m_cnt = 0; end
        else if (!m_pg) begin
          if (m_cnt >= m_tmo) m_pg = 1;
          else m_cnt++;
        end
      end else m_cnt = 0;
      if (ld) m_tmo = int'(ldv);
    end
  end

  always @(negedge clk) begin
    cyc++;
    checks++;
    if (pgood !== m_pg || fault_n !== !m_flt) begin
      fails++;
      $display("FAIL %s cyc %0d: pgood=%b fault_n=%b expected pgood=%b fault_n=%b",
               cur_req, cyc, pgood, fault_n, m_pg, !m_flt);
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired, actual running expected done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_pg(input bit v, input string req);
    checks++;
    if (pgood !== v) begin
      fails++;
      $display("FAIL %s: pgood=%b expected %b", req, pgood, v);
    end
  endtask

  initial begin
    step(2);
    cur_req = "R1";
    expect_pg(0, "R1");
    rst_n = 1'b1;
    good = '1;
    // default timeout of 10000: rises on edge 10001
    step(10000);
    expect_pg(0, "R1");
    step(1);
    expect_pg(1, "R1");

    cur_req = "R9";
    ld = 1'b1; ldv = 16'd5; step(1); ld = 1'b0;
    good[1] = 1'b0; step(1);
    expect_pg(0, "R4");
    good[1] = 1'b1;
    cur_req = "R3";
    step(5); expect_pg(0, "R3");
    step(1); expect_pg(1, "R3");

    cur_req = "R4";
    good[0] = 1'b0; step(1); good[0] = 1'b1;
    step(3);
    good[2] = 1'b0; step(1); good[2] = 1'b1;   // restart mid-count
    step(5); expect_pg(0, "R4");
    step(1); expect_pg(1, "R4");

    cur_req = "R2";
    act[2] = 1'b0; good[2] = 1'b0;
    step(3); expect_pg(1, "R2");
    good[0] = 1'b0; step(1); good[0] = 1'b1;
    step(6); expect_pg(1, "R2");
    act[2] = 1'b1; good[2] = 1'b1;

    cur_req = "R5";
    uv[1] = 1'b0; step(1); expect_pg(0, "R5"); uv[1] = 1'b1;
    step(6); expect_pg(1, "R5");
    en = 1'b0; step(1); expect_pg(0, "R5"); en = 1'b1;
    step(3);
    en = 1'b0; step(1); en = 1'b1;
    step(5); expect_pg(0, "R5");
    step(1); expect_pg(1, "R5");

    cur_req = "R8";
    freq = 1'b1; step(2); freq = 1'b0; step(2);
    freq = 1'b1; step(1);

    cur_req = "R6";
    mrg_n = 1'b0;
    freq = 1'b0; uv[0] = 1'b0; good[1] = 1'b0;
    step(4); expect_pg(1, "R6");
    uv[0] = 1'b1; good[1] = 1'b1;
    mrg_n = 1'b1; step(1);
    freq = 1'b0; step(1);
    en = 1'b0; step(1); en = 1'b1; expect_pg(0, "R6");
    step(2);

    cur_req = "R7";
    mrg_n = 1'b0; step(10); expect_pg(0, "R7");
    mrg_n = 1'b1;
    step(5); expect_pg(0, "R7");
    step(1); expect_pg(1, "R7");

    cur_req = "R9";
    ld = 1'b1; ldv = 16'd0; step(1); ld = 1'b0;
    good[0] = 1'b0; step(1); good[0] = 1'b1;
    step(1); expect_pg(1, "R9");
    step(3);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule